// File: doc/BRIEF.md
# Cluster Core Reset and Start Controller

This block is a small memory-mapped register bank that starts, stops and resets the cores of a four-core processor cluster. Software reaches it with aligned 32-bit reads and writes inside a 4 KB window. The bank holds sixteen words: a control word, two boot-mode words, a reset-status word, an interrupt status word and an interrupt mask word, followed by ten general-purpose words.

A write to the control word is compared bit by bit with the value already held there, and only the bits that change cause an action. When the enable bit of a secondary core goes high, the block sends a one-cycle power-on request to that core. The request carries an entry address and an argument taken from a fixed pair of general-purpose words. When the enable bit goes low, the block sends a power-off request. When a per-core reset bit or one of the two display-unit reset bits changes, the block sends a single reset pulse and the bit reads back as zero. Every other word stores exactly what was written.

Top module: `cluster_reset_ctrl`

## Requirements
- R1: After reset every word reads zero except: control 0x0000_0521, reset status 0x0000_0001, interrupt mask 0x0000_001F. All request outputs are low and the entry address and argument buses are zero.
- R2: The word index is bus_addr[11:2]. Index 0 is control, 1 is boot mode A, 2 is reset status, 3 is interrupt status, 4 is interrupt mask, 5 is boot mode B, and indices 6 to 15 are general-purpose words 1 to 10. A write to any index other than 0 stores bus_wdata unchanged. A read returns the word on bus_rdata one cycle later. bus_rdata is zero in the cycles with no read.
- R3: An access whose bus_addr[1:0] is not zero, or whose index is 16 or above, has no effect on any word. A read of this kind returns zero.
- R4: When a control write raises the enable bit of core c (bit 21+c, c = 1..3), core_on_o[c] pulses high for one cycle, in the cycle after the write. In that same cycle, slice c of boot_addr_o holds general-purpose word 2c+1 and slice c of boot_arg_o holds word 2c+2.
- R5: When a control write lowers the enable bit of core c (c = 1..3), core_off_o[c] pulses high for one cycle, in the cycle after the write.
- R6: When a write changes core c's enable bit, that core's reset bit (bit 13+c) is stored as zero and core_rst_o[c] stays low.
- R7: When a control write changes the reset bit of core c (bit 13+c, c = 0..3) and leaves that core's enable bit unchanged, core_rst_o[c] pulses for one cycle and the bit is stored as zero.
- R8: When a control write sets the display-unit reset bits (bit 3 for unit 0, bit 12 for unit 1), disp_rst_o pulses one cycle for each unit set, and both bits read back as zero.
- R9: A control write that leaves an enable bit at its stored value produces no power-on or power-off request for that core. Core 0 never receives either request.
- R10: The other control bits are stored as written, and the enable bits are stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| core_on_o | output | 4 | Per-core power-on request pulse |
| core_off_o | output | 4 | Per-core power-off request pulse |
| core_rst_o | output | 4 | Per-core reset pulse |
| disp_rst_o | output | 2 | Display-unit reset pulses |
| boot_addr_o | output | 128 | Per-core entry address, 32 bits per core, valid with core_on_o |
| boot_arg_o | output | 128 | Per-core start argument, 32 bits per core, valid with core_on_o |

## Verification
Each output of the block comes from a register. A write that the clock edge captures shows its request pulses, entry address and argument in the cycle right after that edge, and they are gone one cycle later. Read data follows the same rule: it is due one cycle after the read strobe. The bench drives inputs on the falling edge and releases the strobe on the next falling edge. It samples the pulses and the read data at that point, which lies within the cycle they are due. It samples again one cycle later to confirm that each pulse has ended.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int DATA_W      = 32;
    localparam int REG_CTRL    = 0;
    localparam int REG_BOOTA   = 1;
    localparam int REG_RSTAT   = 2;
    localparam int REG_ISTAT   = 3;
    localparam int REG_IMASK   = 4;
    localparam int REG_BOOTB   = 5;
    localparam int REG_GP_BASE = 6;
    localparam int NUM_GP      = 10;
    localparam int NUM_REGS    = REG_GP_BASE + NUM_GP;
    // control word bit positions
    localparam int EN_BIT0     = 21;   // enable of core c at EN_BIT0 + c
    localparam int RST_BIT0    = 13;   // reset of core c at RST_BIT0 + c
    localparam int DISP0_BIT   = 3;
    localparam int DISP1_BIT   = 12;
    localparam logic [DATA_W-1:0] CTRL_INIT  = 32'h0000_0521;
    localparam logic [DATA_W-1:0] RSTAT_INIT = 32'h0000_0001;
    localparam logic [DATA_W-1:0] IMASK_INIT = 32'h0000_001F;

    function automatic logic [DATA_W-1:0] reg_init(input int i);
        case (i)
            REG_CTRL:  return CTRL_INIT;
            REG_RSTAT: return RSTAT_INIT;
            REG_IMASK: return IMASK_INIT;
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/crc_core_lane.sv
module crc_core_lane #(
    parameter bit HAS_ENABLE = 1'b1
) (
    input  logic active,
    input  logic en_old,
    input  logic en_new,
    input  logic rst_old,
    input  logic rst_new,
    output logic on_req,
    output logic off_req,
    output logic rst_req
);
    logic en_chg;
    always_comb begin
        en_chg  = HAS_ENABLE && active && (en_old != en_new);
        on_req  = en_chg && en_new;
        off_req = en_chg && !en_new;
        // an enable change absorbs the reset bit of the same core
        rst_req = active && !en_chg && (rst_old != rst_new);
    end
endmodule

// File: rtl/crc_rd_mux.sv
module crc_rd_mux #(
    parameter int N     = 16,
    parameter int W     = 32,
    parameter int SEL_W = $clog2(N)
) (
    input  logic [N-1:0][W-1:0] words,
    input  logic [SEL_W-1:0]    sel,
    input  logic                valid,
    output logic [W-1:0]        data
);
    always_comb begin
        data = '0;
        if (valid) data = words[sel];
    end
endmodule

// File: rtl/cluster_reset_ctrl.sv
module cluster_reset_ctrl
    import crc_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic [NUM_CORES-1:0]          core_on_o,
    output logic [NUM_CORES-1:0]          core_off_o,
    output logic [NUM_CORES-1:0]          core_rst_o,
    output logic [1:0]                    disp_rst_o,
    output logic [NUM_CORES*DATA_W-1:0]   boot_addr_o,
    output logic [NUM_CORES*DATA_W-1:0]   boot_arg_o
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int SEL_W = $clog2(NUM_REGS);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0]  regs;
        logic [DATA_W-1:0]                rdata;
        logic [NUM_CORES-1:0]             on;
        logic [NUM_CORES-1:0]             off;
        logic [NUM_CORES-1:0]             rst;
        logic [1:0]                       disp;
        logic [NUM_CORES-1:0][DATA_W-1:0] addr;
        logic [NUM_CORES-1:0][DATA_W-1:0] arg;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0]     idx;
    logic [SEL_W-1:0]     sel;
    logic                 acc_ok, wr_ok, rd_ok, ctrl_wr;
    logic [DATA_W-1:0]    ctrl_old, rd_word;
    logic [NUM_CORES-1:0] ln_on, ln_off, ln_rst;

    always_comb begin
        idx      = bus_addr[ADDR_W-1:2];
        sel      = idx[SEL_W-1:0];
        acc_ok   = (bus_addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));
        wr_ok    = bus_wr && acc_ok;
        rd_ok    = bus_rd && acc_ok;
        ctrl_wr  = wr_ok && (sel == SEL_W'(REG_CTRL));
        ctrl_old = st_q.regs[REG_CTRL];
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
        if (c == 0) begin : g_boot
            crc_core_lane #(.HAS_ENABLE(1'b0)) u_lane (
                .active (ctrl_wr),
                .en_old (1'b0),
                .en_new (1'b0),
                .rst_old(ctrl_old[RST_BIT0+c]),
                .rst_new(bus_wdata[RST_BIT0+c]),
                .on_req (ln_on[c]),
                .off_req(ln_off[c]),
                .rst_req(ln_rst[c])
            );
        end else begin : g_sec
            crc_core_lane #(.HAS_ENABLE(1'b1)) u_lane (
                .active (ctrl_wr),
                .en_old (ctrl_old[EN_BIT0+c]),
                .en_new (bus_wdata[EN_BIT0+c]),
                .rst_old(ctrl_old[RST_BIT0+c]),
                .rst_new(bus_wdata[RST_BIT0+c]),
                .on_req (ln_on[c]),
                .off_req(ln_off[c]),
                .rst_req(ln_rst[c])
            );
        end
    end

    crc_rd_mux #(.N(NUM_REGS), .W(DATA_W), .SEL_W(SEL_W)) u_rd (
        .words(st_q.regs),
        .sel  (sel),
        .valid(rd_ok),
        .data (rd_word)
    );

    always_comb begin
        logic [DATA_W-1:0] nv;
        st_d       = st_q;
        st_d.rdata = rd_word;
        st_d.on    = '0;
        st_d.off   = '0;
        st_d.rst   = '0;
        st_d.disp  = '0;
        st_d.addr  = '0;
        st_d.arg   = '0;
        nv         = bus_wdata;
        if (ctrl_wr) begin
            for (int c = 0; c < NUM_CORES; c++) nv[RST_BIT0+c] = 1'b0;
            nv[DISP0_BIT] = 1'b0;
            nv[DISP1_BIT] = 1'b0;
            st_d.regs[REG_CTRL] = nv;
            st_d.on   = ln_on;
            st_d.off  = ln_off;
            st_d.rst  = ln_rst;
            st_d.disp = {ctrl_old[DISP1_BIT] ^ bus_wdata[DISP1_BIT],
                         ctrl_old[DISP0_BIT] ^ bus_wdata[DISP0_BIT]};
            for (int c = 0; c < NUM_CORES; c++) begin
                if (ln_on[c]) begin
                    st_d.addr[c] = st_q.regs[REG_GP_BASE + 2*c];
                    st_d.arg[c]  = st_q.regs[REG_GP_BASE + 2*c + 1];
                end
            end
        end else if (wr_ok) begin
            st_d.regs[sel] = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NUM_REGS; i++) st_q.regs[i] <= reg_init(i);
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata   = st_q.rdata;
    assign core_on_o   = st_q.on;
    assign core_off_o  = st_q.off;
    assign core_rst_o  = st_q.rst;
    assign disp_rst_o  = st_q.disp;
    assign boot_addr_o = st_q.addr;
    assign boot_arg_o  = st_q.arg;

    // R7
    ctrl_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.regs[REG_CTRL][RST_BIT0 +: NUM_CORES] == '0);
    // R8
    disp_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.regs[REG_CTRL][DISP0_BIT] && !st_q.regs[REG_CTRL][DISP1_BIT]);
    // R5
    on_off_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_on_o & core_off_o) == '0);
    // R9
    boot_core_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_on_o[0] && !core_off_o[0]);
    // R4
    on_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_on_o) |-> $past(bus_wr && bus_addr == '0));

    for (genvar c = 1; c < NUM_CORES; c++) begin : g_chk
        // R4
        on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            core_on_o[c] |-> (boot_addr_o[c*DATA_W +: DATA_W] ==
                              $past(st_q.regs[REG_GP_BASE + 2*c])));
        // R4
        on_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            core_on_o[c] |=> !core_on_o[c]);
        // R6
        en_blocks_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (core_on_o[c] || core_off_o[c]) |-> !core_rst_o[c]);
    end
endmodule

// File: tb/tb_cluster_reset_ctrl.sv
module tb_cluster_reset_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [3:0]   core_on_o, core_off_o, core_rst_o;
    logic [1:0]   disp_rst_o;
    logic [127:0] boot_addr_o, boot_arg_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cluster_reset_ctrl dut (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // outputs sampled at the falling edge right after the capturing edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic quiet_next(input string req);
        @(negedge clk);
        chk(req, {core_on_o, core_off_o, core_rst_o, disp_rst_o}, '0);
    endtask

    localparam logic [31:0] INIT = 32'h521;

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 outputs", {core_on_o, core_off_o, core_rst_o, disp_rst_o, boot_addr_o, boot_arg_o}, '0);
        for (int i = 0; i < 16; i++) begin
            rd(12'(i*4), v);
            chk("R1 reset word", v, (i == 0) ? INIT : (i == 2) ? 32'h1 : (i == 4) ? 32'h1F : 32'h0);
        end
        @(negedge clk);
        chk("R2 rdata idle", bus_rdata, '0);
    endtask

    task automatic t_store();
        logic [31:0] v;
        for (int i = 1; i < 16; i++) wr(12'(i*4), 32'hA500_0000 + 32'(i * 32'h111));
        for (int i = 1; i < 16; i++) begin
            rd(12'(i*4), v);
            chk("R2 store", v, 32'hA500_0000 + 32'(i * 32'h111));
        end
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr(12'h040, 32'hDEAD_0001);
        rd(12'h040, v);
        chk("R3 index 16 read", v, '0);
        wr(12'h01A, 32'hBAD0_BAD0);            // unaligned onto word 6
        rd(12'h018, v);
        chk("R3 unaligned write ignored", v, 32'hA500_0000 + 32'(6 * 32'h111));
        rd(12'h019, v);
        chk("R3 unaligned read", v, '0);
        rd(12'hFFC, v);
        chk("R3 top of window", v, '0);
    endtask

    task automatic t_start();
        logic [31:0] v;
        wr(12'h020, 32'h1000_0100); wr(12'h024, 32'h2000_0001);   // core 1
        wr(12'h028, 32'h1000_0200); wr(12'h02C, 32'h2000_0002);   // core 2
        wr(12'h030, 32'h1000_0300); wr(12'h034, 32'h2000_0003);   // core 3
        wr(12'h000, INIT | (32'h1 << 22) | (32'h1 << 14));
        chk("R4 on core1", core_on_o, 4'b0010);
        chk("R4 entry addr", boot_addr_o[63:32], 32'h1000_0100);
        chk("R4 entry arg", boot_arg_o[63:32], 32'h2000_0001);
        chk("R6 no reset with enable", core_rst_o, 4'b0000);
        quiet_next("R4 pulse ends");
        rd(12'h000, v);
        chk("R6 stored", v, INIT | (32'h1 << 22));
        wr(12'h000, INIT | (32'h7 << 22) | (32'h1 << 13));
        chk("R4 on core2+3", core_on_o, 4'b1100);
        chk("R4 addr core3", boot_addr_o[127:96], 32'h1000_0300);
        chk("R4 arg core2", boot_arg_o[95:64], 32'h2000_0002);
        chk("R7 core0 reset", core_rst_o, 4'b0001);
        quiet_next("R7 pulse ends");
    endtask

    task automatic t_same();
        wr(12'h000, INIT | (32'h7 << 22));
        chk("R9 no request", {core_on_o, core_off_o}, '0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(12'h000, INIT | (32'h5 << 22) | (32'h1 << 15));
        chk("R5 off core2", core_off_o, 4'b0100);
        chk("R6 rst absorbed", core_rst_o, 4'b0000);
        quiet_next("R5 pulse ends");
        rd(12'h000, v);
        chk("R10 enables stored", v, INIT | (32'h5 << 22));
    endtask

    task automatic t_resets();
        logic [31:0] v;
        wr(12'h000, INIT | (32'h5 << 22) | (32'h9 << 13) | 32'h2);
        chk("R7 reset 0 and 3", core_rst_o, 4'b1001);
        quiet_next("R7 single pulse");
        rd(12'h000, v);
        chk("R10 other bits", v, INIT | (32'h5 << 22) | 32'h2);
        wr(12'h000, INIT | (32'h5 << 22) | (32'h1 << 3) | (32'h1 << 12));
        chk("R8 display pulses", disp_rst_o, 2'b11);
        quiet_next("R8 pulse ends");
        rd(12'h000, v);
        chk("R8 self clear", v, INIT | (32'h5 << 22));
        wr(12'h000, INIT | (32'h5 << 22) | (32'h1 << 12));
        chk("R8 unit 1 only", disp_rst_o, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_store();
        t_ignored();
        t_start();
        t_same();
        t_stop();
        t_resets();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule